// File: doc/BRIEF.md
# Clock Level Best-Match Search

This block picks the best source clock for a requested output rate. It holds a table of up to `DEPTH` source frequencies, filled through a plain write port. On a start pulse it walks the first `level_count` entries in index order. For each entry it works out the smallest integer divider that keeps the divided rate at or below the request. It then measures how far that divided rate falls short of the request.

The entry with the smallest shortfall wins. An entry that meets the request exactly ends the scan at once. Each entry costs two sequential divisions: a ceiling division that yields the divider and a truncating division that yields the divided rate. A scan therefore takes a number of cycles proportional to the entries visited, and the block needs no wide combinational divider.

When the scan ends, a one-cycle `done` pulse carries the winning index, its source frequency and an error flag. The result outputs hold their values until the next result. An exact-only request that finds no exact match is flagged as an error, but the closest entry is still reported.

Top module: `clk_level_search`

## Requirements
- R1: A write with `tbl_we` high stores `tbl_data` at entry `tbl_addr`. A search considers only entries 0 to N-1, where N is `level_count` limited to `DEPTH`. The reported index on success is always below N.
- R2: For each entry, the divider is the ceiling of the entry frequency divided by the request. A divider of zero, which comes from a zero-valued entry, is treated as 1.
- R3: The shortfall of an entry is the request minus the truncated quotient of the entry frequency by its divider. This divided rate never exceeds the request.
- R4: An entry replaces the current best only when its shortfall is strictly smaller. The first entry always becomes the initial best, and ties keep the lower index.
- R5: An entry with zero shortfall ends the scan at once with `err`=0 and that index, so later entries are not visited and the latency is shorter.
- R6: With `exact_only`=1 and no zero-shortfall entry among the N, the result has `err`=1 and still carries the closest entry's index and frequency.
- R7: With `exact_only`=0, a scan always ends with `err`=0 and the closest entry.
- R8: A start with `level_count`=0 gives `done` with `err`=1, index 0 and frequency 0.
- R9: A start with `req_freq`=0 is rejected without a scan. In that case `done` and `err` are high on the cycle after the start, and index and frequency are 0.
- R10: `done` is high for exactly one cycle per accepted start. `res_idx` and `res_freq` change only in a cycle where `done` is high. A start that arrives while `busy` is high is ignored.
- R11: After reset, `busy`, `done` and `err` are 0 and `res_idx` and `res_freq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | IDX_W | Table write index |
| tbl_data | input | FREQ_W | Source frequency to store |
| level_count | input | CNT_W | Number of valid entries, sampled at start |
| start | input | 1 | Request pulse, accepted when idle |
| req_freq | input | FREQ_W | Requested output frequency |
| exact_only | input | 1 | Demand a zero-shortfall match |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Failure flag, valid with done |
| res_idx | output | IDX_W | Winning entry index |
| res_freq | output | FREQ_W | Winning entry source frequency |

## Verification
Some properties are checked on every cycle:
- `done` lasts a single cycle.
- The result outputs move only on `done`.
- A successful index lies below the clamped count.
- A zero request is rejected on the next cycle.
- Every divided rate stays at or below the request.
- Each remainder stays under its divisor.

The bench scenarios cover the rest: which entry wins under ties, early exit on an exact hit, the exact-only failure, the count limit and clamping, zero-valued entries, and ignored restarts. These can only be judged against expected indices and frequencies worked out by hand.

// File: rtl/clk_search_pkg.sv
package clk_search_pkg;
  typedef enum logic [2:0] {
    SCH_IDLE,
    SCH_READ,
    SCH_LOAD,
    SCH_CEIL,
    SCH_TRUNC
  } sch_state_t;
endpackage

// File: rtl/rate_table.sv
module rate_table #(
  parameter int DEPTH = 32,
  parameter int W     = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  // Synchronous write and registered read so block RAM can be inferred.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/serial_div.sv
module serial_div #(
  parameter int W    = 32,
  parameter bit CEIL = 1'b0,
  localparam int CW  = $clog2(W + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         done,
  output logic [W-1:0] quot
);
  logic [W-1:0]  acc;
  logic [W-1:0]  q;
  logic [W-1:0]  den;
  logic [CW-1:0] cnt;
  logic          run;
  logic [W:0]    trial;
  logic          fits;

  // Restoring division: one quotient bit per cycle.
  assign trial = {acc, q[W-1]};
  assign fits  = trial >= {1'b0, den};

  always_ff @(posedge clk) begin
    if (rst) begin
      acc  <= '0;
      q    <= '0;
      den  <= '0;
      cnt  <= '0;
      run  <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !run) begin
        acc <= '0;
        q   <= dividend;
        den <= divisor;
        cnt <= CW'(W);
        run <= 1'b1;
      end else if (run) begin
        acc <= fits ? W'(trial - {1'b0, den}) : trial[W-1:0];
        q   <= {q[W-2:0], fits};
        cnt <= cnt - CW'(1);
        if (cnt == CW'(1)) begin
          run  <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  generate
    if (CEIL) begin : g_ceil
      assign quot = q + W'(acc != '0);
    end else begin : g_trunc
      assign quot = q;
    end
  endgenerate

  AST_DIV_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (rst)
    (done && den != '0) |-> acc < den); // R2
endmodule

// File: rtl/clk_level_search.sv
module clk_level_search
  import clk_search_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int FREQ_W = 32,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tbl_we,
  input  logic [IDX_W-1:0]  tbl_addr,
  input  logic [FREQ_W-1:0] tbl_data,
  input  logic [CNT_W-1:0]  level_count,
  input  logic              start,
  input  logic [FREQ_W-1:0] req_freq,
  input  logic              exact_only,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [IDX_W-1:0]  res_idx,
  output logic [FREQ_W-1:0] res_freq
);
  sch_state_t        state;
  logic [FREQ_W-1:0] req_q;
  logic              exact_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  lc_clamp;
  logic [IDX_W-1:0]  idx;
  logic [FREQ_W-1:0] ent_q;
  logic [FREQ_W:0]   best_err;
  logic [IDX_W-1:0]  best_idx;
  logic [FREQ_W-1:0] best_freq;

  logic [FREQ_W-1:0] rd_data;
  logic              c_start, c_done, t_start, t_done;
  logic [FREQ_W-1:0] c_quot, t_quot, t_divisor;
  logic [FREQ_W-1:0] delta;
  logic              better, hit, last;

  assign lc_clamp = (level_count > CNT_W'(DEPTH)) ? CNT_W'(DEPTH) : level_count;

  rate_table #(.DEPTH(DEPTH), .W(FREQ_W)) u_table (
    .clk   (clk),
    .we    (tbl_we),
    .waddr (tbl_addr),
    .wdata (tbl_data),
    .re    (state == SCH_READ),
    .raddr (idx),
    .rdata (rd_data)
  );

  assign c_start = (state == SCH_LOAD);

  serial_div #(.W(FREQ_W), .CEIL(1'b1)) u_ceil_div (
    .clk      (clk),
    .rst      (rst),
    .start    (c_start),
    .dividend (rd_data),
    .divisor  (req_q),
    .done     (c_done),
    .quot     (c_quot)
  );

  assign t_divisor = (c_quot == '0) ? FREQ_W'(1) : c_quot;
  assign t_start   = (state == SCH_CEIL) && c_done;

  serial_div #(.W(FREQ_W), .CEIL(1'b0)) u_trunc_div (
    .clk      (clk),
    .rst      (rst),
    .start    (t_start),
    .dividend (ent_q),
    .divisor  (t_divisor),
    .done     (t_done),
    .quot     (t_quot)
  );

  assign delta  = req_q - t_quot;
  assign better = {1'b0, delta} < best_err;
  assign hit    = (delta == '0);
  assign last   = (CNT_W'(idx) + CNT_W'(1)) == cnt_q;
  assign busy   = (state != SCH_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SCH_IDLE;
      req_q     <= '0;
      exact_q   <= 1'b0;
      cnt_q     <= '0;
      idx       <= '0;
      ent_q     <= '0;
      best_err  <= '1;
      best_idx  <= '0;
      best_freq <= '0;
      done      <= 1'b0;
      err       <= 1'b0;
      res_idx   <= '0;
      res_freq  <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        SCH_IDLE: begin
          if (start) begin
            if (req_freq == '0 || lc_clamp == '0) begin
              done     <= 1'b1;
              err      <= 1'b1;
              res_idx  <= '0;
              res_freq <= '0;
            end else begin
              req_q    <= req_freq;
              exact_q  <= exact_only;
              cnt_q    <= lc_clamp;
              idx      <= '0;
              best_err <= '1;
              state    <= SCH_READ;
            end
          end
        end
        SCH_READ: state <= SCH_LOAD;
        SCH_LOAD: begin
          ent_q <= rd_data;
          state <= SCH_CEIL;
        end
        SCH_CEIL: if (c_done) state <= SCH_TRUNC;
        SCH_TRUNC: begin
          if (t_done) begin
            if (hit) begin
              done     <= 1'b1;
              err      <= 1'b0;
              res_idx  <= idx;
              res_freq <= ent_q;
              state    <= SCH_IDLE;
            end else if (last) begin
              done     <= 1'b1;
              err      <= exact_q;
              res_idx  <= better ? idx : best_idx;
              res_freq <= better ? ent_q : best_freq;
              state    <= SCH_IDLE;
            end else begin
              if (better) begin
                best_err  <= {1'b0, delta};
                best_idx  <= idx;
                best_freq <= ent_q;
              end
              idx   <= idx + IDX_W'(1);
              state <= SCH_READ;
            end
          end
        end
        default: state <= SCH_IDLE;
      endcase
    end
  end

  AST_DONE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R10
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(res_idx) && $stable(res_freq))); // R10
  AST_IDX_BELOW_COUNT: assert property (@(posedge clk) disable iff (rst)
    (done && !err) |-> (CNT_W'(res_idx) < cnt_q)); // R1
  AST_ZERO_REQ_REJECT: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && req_freq == '0) |=> (done && err && !busy)); // R9
  AST_RATE_NOT_ABOVE_REQ: assert property (@(posedge clk) disable iff (rst)
    (state == SCH_TRUNC && t_done) |-> (t_quot <= req_q)); // R3
endmodule

// File: tb/tb_clk_level_search.sv
module tb_clk_level_search;
  localparam int DEPTH  = 32;
  localparam int FREQ_W = 32;
  localparam int IDX_W  = $clog2(DEPTH);
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int NV     = 15;

  // Vectors: request, count, exact, expected err, index, frequency.
  localparam int V_REQ [NV] = '{16, 16, 33, 33, 50, 50, 50, 1000, 1000, 7, 7, 1, 200, 500, 7};
  localparam int V_CNT [NV] = '{6, 6, 6, 6, 6, 3, 3, 6, 6, 7, 6, 6, 6, 8, 6};
  localparam int V_EX  [NV] = '{0, 1, 0, 1, 0, 0, 1, 0, 1, 1, 0, 1, 1, 0, 1};
  localparam int V_ERR [NV] = '{0, 0, 0, 1, 0, 0, 1, 0, 1, 0, 0, 0, 0, 0, 1};
  localparam int V_IDX [NV] = '{2, 2, 2, 2, 3, 1, 1, 5, 5, 6, 0, 0, 5, 5, 0};
  localparam int V_FRQ [NV] = '{64, 64, 64, 64, 100, 45, 45, 200, 200, 7, 30, 30, 200, 200, 30};

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              tbl_we = 1'b0;
  logic [IDX_W-1:0]  tbl_addr = '0;
  logic [FREQ_W-1:0] tbl_data = '0;
  logic [CNT_W-1:0]  level_count = '0;
  logic              start = 1'b0;
  logic [FREQ_W-1:0] req_freq = '0;
  logic              exact_only = 1'b0;
  logic              busy, done, err;
  logic [IDX_W-1:0]  res_idx;
  logic [FREQ_W-1:0] res_freq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  clk_level_search #(.DEPTH(DEPTH), .FREQ_W(FREQ_W)) dut (
    .clk(clk), .rst(rst), .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_data(tbl_data),
    .level_count(level_count), .start(start), .req_freq(req_freq), .exact_only(exact_only),
    .busy(busy), .done(done), .err(err), .res_idx(res_idx), .res_freq(res_freq)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired act=%0d exp<190000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    tbl_we = 1'b1; tbl_addr = IDX_W'(a); tbl_data = FREQ_W'(d);
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic search(input int rq, input int cn, input int ex, output int lat);
    @(negedge clk);
    start = 1'b1; req_freq = FREQ_W'(rq); level_count = CNT_W'(cn); exact_only = ex[0];
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done) begin
      @(negedge clk);
      lat = lat + 1;
    end
  endtask

  initial begin
    int lat, lat_hit, lat_full, pulses;
    logic [IDX_W-1:0] hold_idx;
    logic [FREQ_W-1:0] hold_freq;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(!busy && !done && !err, "R11 status after reset", {busy, done, err}, 0);
    chk(res_idx == 0 && res_freq == 0, "R11 result after reset", res_freq, 0);
    rst = 1'b0;
    // R1: table load
    wr(0, 30); wr(1, 45); wr(2, 64); wr(3, 100); wr(4, 96); wr(5, 200); wr(6, 7); wr(7, 0);
    for (int i = 8; i < 31; i++) wr(i, i + 10);
    wr(31, 4000);

    // Vector walk covering R1..R7
    for (int v = 0; v < NV; v++) begin
      search(V_REQ[v], V_CNT[v], V_EX[v], lat);
      chk(err == V_ERR[v][0], $sformatf("R6 R7 err vector %0d", v), err, V_ERR[v]);
      chk(res_idx == IDX_W'(V_IDX[v]), $sformatf("R4 R5 idx vector %0d", v), res_idx, V_IDX[v]);
      chk(res_freq == FREQ_W'(V_FRQ[v]), $sformatf("R2 R3 freq vector %0d", v), res_freq, V_FRQ[v]);
    end

    // R5: exact hit at entry 0 finishes sooner than a full six-entry scan
    search(1, 6, 0, lat_hit);
    search(1000, 6, 0, lat_full);
    chk(lat_hit < lat_full, "R5 early exit latency", lat_hit, lat_full);

    // R10: single pulse and held result
    hold_idx = res_idx; hold_freq = res_freq;
    pulses = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (done) pulses++;
    end
    chk(pulses == 0, "R10 no extra done pulse", pulses, 0);
    chk(res_idx == hold_idx && res_freq == hold_freq, "R10 result held", res_freq, hold_freq);

    // R10: start while busy ignored
    @(negedge clk);
    start = 1'b1; req_freq = 33; level_count = 6; exact_only = 1'b0;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    start = 1'b1; req_freq = 50;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    chk(res_idx == 2 && res_freq == 64, "R10 busy start ignored", res_idx, 2);
    pulses = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (done) pulses++;
    end
    chk(pulses == 0, "R10 ignored start leaves no second result", pulses, 0);

    // R9: zero request rejected on next cycle
    search(0, 6, 0, lat);
    chk(lat == 1, "R9 zero request latency", lat, 1);
    chk(err && res_idx == 0 && res_freq == 0, "R9 zero request error", err, 1);

    // R8: empty table
    search(50, 0, 0, lat);
    chk(err && res_idx == 0 && res_freq == 0, "R8 empty table error", err, 1);

    // R1: count above DEPTH clamps to DEPTH
    search(5000, 63, 0, lat);
    chk(!err && res_idx == 31 && res_freq == 4000, "R1 clamped count", res_freq, 4000);

    // R1: rewrite an entry and observe it in a search
    wr(0, 33);
    search(33, 6, 1, lat);
    chk(!err && res_idx == 0 && res_freq == 33, "R1 rewritten entry", res_freq, 33);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule